// File: doc/BRIEF.md
# Prioritised Event Interrupt Controller

This block gathers event requests from up to eight numbered sources inside a sound subsystem and turns them into one fast-interrupt request line for the embedded processor. Each request sets a pending bit. A small register holds the number of the event that the processor should service. When a request arrives, this register takes the new number if the new number is smaller than the current value, or if the current value is zero. The register is not recomputed from the pending bits on every cycle.

The processor retires events through a register write port. Writes to the clear address are counted, and only every fourth write retires an event. That write removes the lowest-numbered pending bit. The reported number then moves to the lowest pending bit that remains. A second address lets software overwrite the reported number directly. After reset, the timer event (number 2) is already pending, so the interrupt line is high from the start.

The design uses two state machines. The clear counter has the states `CLR_ARMED` (no clear writes counted), `CLR_COUNTING` (some writes counted) and `CLR_FINAL` (the next clear write retires). A clear write moves ARMED→COUNTING, COUNTING→COUNTING or COUNTING→FINAL once three writes have been seen, and FINAL→ARMED together with a retire. The interrupt line has the states `IRQ_QUIET` and `IRQ_RAISED`. It moves QUIET→RAISED when the next pending set is non-empty and RAISED→QUIET when a retire empties it.

Top module: `evc_irq_ctrl`

## Requirements
- R1: After reset, event 2 is the only pending event, the interrupt output is 1, the reported number is 2 and the clear count is zero.
- R2: An event strobe makes the interrupt output 1 at the next clock edge, whatever was pending before.
- R3: On an event strobe, the reported number takes the new event number only if the reported number is 0 or the new number is smaller; otherwise it keeps its value.
- R4: Writes to the clear address (reg_addr = 1) are counted modulo four. The first, second and third writes of each group change neither output.
- R5: The fourth clear write clears the lowest-numbered pending bit. The reported number becomes the lowest pending index that remains. If none remains, the reported number is left unchanged.
- R6: The interrupt output is 1 exactly when at least one pending bit is set. When a retire leaves no pending bits, it drops to 0.
- R7: When an event strobe and a retiring clear write fall in the same cycle, the retire is applied first and the new request is applied to the result.
- R8: A write to the number address (reg_addr = 0) loads reg_wdata into the reported number. An event strobe in the same cycle is compared against the written value.
- R9: Writes to any other address change no output and do not advance the clear count.
- R10: Both outputs are registered. They change at the first clock edge after the strobe or write that causes the change, never before.
- R11: A fourth clear write with nothing pending still restarts the clear count and changes neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event strobe, one cycle per request |
| ev_num | input | 3 | Number of the requesting event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Write address: 0 = reported number, 1 = clear |
| reg_wdata | input | 3 | Write data for the reported number |
| irq_o | output | 1 | Fast-interrupt request to the processor |
| event_num_o | output | 3 | Reported event number |

## Verification
The bench goes after the stale-number case first. When event 5 arrives while the number still shows an already retired 2, the number stays at 2. A design that re-derived the number from the pending bits would report 5. It also checks that a zero number is always overwritten, including when event 0 itself is pending. The bench covers a retire and a request in the same cycle: a design that applied the request before the retire would clear the new bit or report the wrong number. It also checks that the first three clear writes are silent and that other addresses do not advance the count, because an off-by-one counter retires events too early. A constrained-random phase mixes strobes, clear writes, number writes and stray writes against a model in the bench.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // Clear-write counter states
    typedef enum logic [1:0] {
        CLR_ARMED    = 2'd0,
        CLR_COUNTING = 2'd1,
        CLR_FINAL    = 2'd2
    } clr_state_t;

    // Interrupt line states
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

endpackage

// File: rtl/evc_clear_fsm.sv
module evc_clear_fsm
    import evc_pkg::*;
#(
    parameter int CLEAR_WRITES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_we,
    output logic retire
);
    localparam int CNT_W = (CLEAR_WRITES > 2) ? $clog2(CLEAR_WRITES) : 1;
    localparam logic [CNT_W-1:0] LAST_MID = CNT_W'(CLEAR_WRITES - 2);

    clr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CLR_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr_we) begin
            unique case (state_q)
                CLR_ARMED: begin
                    if (CLEAR_WRITES <= 2) begin
                        state_d = CLR_FINAL;
                    end else begin
                        state_d = CLR_COUNTING;
                        cnt_d   = CNT_W'(1);
                    end
                end
                CLR_COUNTING: begin
                    if (cnt_q == LAST_MID) begin
                        state_d = CLR_FINAL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                CLR_FINAL: begin
                    state_d = CLR_ARMED;
                    cnt_d   = '0;
                end
                default: begin
                    state_d = CLR_ARMED;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        retire = 1'b0;
        unique case (state_q)
            CLR_FINAL:    retire = clr_we;
            CLR_ARMED,
            CLR_COUNTING: retire = 1'b0;
            default:      retire = 1'b0;
        endcase
    end

    AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && state_q != CLR_FINAL) |=> (state_q != CLR_ARMED)); // R4
    AST_FINAL_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && state_q == CLR_FINAL) |=> (state_q == CLR_ARMED)); // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> $stable(state_q)); // R9

endmodule

// File: rtl/evc_pending.sv
module evc_pending #(
    parameter int NUM_EVENTS  = 8,
    parameter int RESET_EVENT = 2,
    localparam int EV_W       = $clog2(NUM_EVENTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  retire,
    input  logic                  ev_valid,
    input  logic [EV_W-1:0]       ev_num,
    output logic [NUM_EVENTS-1:0] pend_q,
    output logic [NUM_EVENTS-1:0] pend_next,
    output logic [EV_W-1:0]       next_idx,
    output logic                  next_found
);
    localparam logic [NUM_EVENTS-1:0] RESET_MASK = NUM_EVENTS'(1) << RESET_EVENT;

    logic [NUM_EVENTS-1:0] after_ret;
    logic [NUM_EVENTS-1:0] req_mask;

    // Retire first: drop the lowest set bit
    always_comb begin
        after_ret = pend_q;
        if (retire) begin
            after_ret = pend_q & (pend_q - NUM_EVENTS'(1));
        end
    end

    // Lowest set bit among the survivors
    always_comb begin
        next_idx   = '0;
        next_found = 1'b0;
        for (int i = NUM_EVENTS - 1; i >= 0; i--) begin
            if (after_ret[i]) begin
                next_idx   = EV_W'(i);
                next_found = 1'b1;
            end
        end
    end

    // New request applied after the retire
    always_comb begin
        req_mask = '0;
        if (ev_valid) begin
            req_mask = NUM_EVENTS'(1) << ev_num;
        end
        pend_next = after_ret | req_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= RESET_MASK;
        end else begin
            pend_q <= pend_next;
        end
    end

    AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> pend_q[$past(ev_num)]); // R7
    AST_RETIRE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !ev_valid && pend_q != '0) |=>
        ($countones(pend_q) == $countones($past(pend_q)) - 1)); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !ev_valid) |=> $stable(pend_q)); // R9

endmodule

// File: rtl/evc_number.sv
module evc_number #(
    parameter int NUM_EVENTS  = 8,
    parameter int RESET_EVENT = 2,
    localparam int EV_W       = $clog2(NUM_EVENTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retire,
    input  logic            next_found,
    input  logic [EV_W-1:0] next_idx,
    input  logic            num_we,
    input  logic [EV_W-1:0] num_wdata,
    input  logic            ev_valid,
    input  logic [EV_W-1:0] ev_num,
    output logic [EV_W-1:0] num_q
);
    logic [EV_W-1:0] base;
    logic [EV_W-1:0] num_d;

    always_comb begin
        base = num_q;
        if (retire && next_found) begin
            base = next_idx;
        end
        if (num_we) begin
            base = num_wdata;
        end
        num_d = base;
        if (ev_valid && (base == '0 || ev_num < base)) begin
            num_d = ev_num;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q <= EV_W'(RESET_EVENT);
        end else begin
            num_q <= num_d;
        end
    end

    AST_SMALLER_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !retire && !num_we && ev_num < num_q) |=> (num_q == $past(ev_num))); // R3
    AST_LARGER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !retire && !num_we && num_q != '0 && ev_num >= num_q) |=> $stable(num_q)); // R3
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (num_we && !ev_valid) |=> (num_q == $past(num_wdata))); // R8

endmodule

// File: rtl/evc_irq_ctrl.sv
module evc_irq_ctrl
    import evc_pkg::*;
#(
    parameter int NUM_EVENTS   = 8,
    parameter int RESET_EVENT  = 2,
    parameter int CLEAR_WRITES = 4,
    parameter int ADDR_W       = 4,
    parameter int NUM_ADDR     = 0,
    parameter int CLR_ADDR     = 1,
    localparam int EV_W        = $clog2(NUM_EVENTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [EV_W-1:0]   ev_num,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [EV_W-1:0]   reg_wdata,
    output logic              irq_o,
    output logic [EV_W-1:0]   event_num_o
);
    logic                  clr_we;
    logic                  num_we;
    logic                  retire;
    logic [NUM_EVENTS-1:0] pend_q;
    logic [NUM_EVENTS-1:0] pend_next;
    logic [EV_W-1:0]       next_idx;
    logic                  next_found;
    irq_state_t            irq_q, irq_d;

    assign clr_we = reg_wr && (reg_addr == ADDR_W'(CLR_ADDR));
    assign num_we = reg_wr && (reg_addr == ADDR_W'(NUM_ADDR));

    evc_clear_fsm #(
        .CLEAR_WRITES (CLEAR_WRITES)
    ) u_clear (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_we (clr_we),
        .retire (retire)
    );

    evc_pending #(
        .NUM_EVENTS  (NUM_EVENTS),
        .RESET_EVENT (RESET_EVENT)
    ) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire     (retire),
        .ev_valid   (ev_valid),
        .ev_num     (ev_num),
        .pend_q     (pend_q),
        .pend_next  (pend_next),
        .next_idx   (next_idx),
        .next_found (next_found)
    );

    evc_number #(
        .NUM_EVENTS  (NUM_EVENTS),
        .RESET_EVENT (RESET_EVENT)
    ) u_number (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire     (retire),
        .next_found (next_found),
        .next_idx   (next_idx),
        .num_we     (num_we),
        .num_wdata  (reg_wdata),
        .ev_valid   (ev_valid),
        .ev_num     (ev_num),
        .num_q      (event_num_o)
    );

    // Interrupt state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= IRQ_RAISED;
        end else begin
            irq_q <= irq_d;
        end
    end

    // Interrupt transitions
    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_QUIET:  if (pend_next != '0) irq_d = IRQ_RAISED;
            IRQ_RAISED: if (pend_next == '0) irq_d = IRQ_QUIET;
            default:    irq_d = IRQ_QUIET;
        endcase
    end

    // Output decode
    always_comb begin
        unique case (irq_q)
            IRQ_RAISED: irq_o = 1'b1;
            IRQ_QUIET:  irq_o = 1'b0;
            default:    irq_o = 1'b0;
        endcase
    end

    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> irq_o); // R2
    AST_IRQ_MATCHES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (pend_q != '0)); // R6
    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(retire)); // R6
    AST_IRQ_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid && !retire) |=> $stable(irq_o)); // R10

endmodule

// File: tb/evc_irq_ctrl_test.sv
`timescale 1ns/1ps
module evc_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [2:0] ev_num = '0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [2:0] reg_wdata = '0;
    logic       irq_o;
    logic [2:0] event_num_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model
    logic [7:0] m_pend;
    logic [2:0] m_num;
    int         m_cnt;

    always #5 clk = ~clk;

    evc_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_num(ev_num),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .irq_o(irq_o), .event_num_o(event_num_o)
    );

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    task automatic model_step(input bit ev, input logic [2:0] en,
                              input bit wr, input logic [3:0] ad, input logic [2:0] wd);
        bit ret = 0;
        if (wr && ad == 4'd1) begin
            if (m_cnt == 3) begin ret = 1; m_cnt = 0; end
            else m_cnt++;
        end
        if (ret) begin
            int lo = lowest(m_pend);
            if (lo < 8) m_pend[lo] = 1'b0;
            lo = lowest(m_pend);
            if (lo < 8) m_num = 3'(lo);
        end
        if (wr && ad == 4'd0) m_num = wd;
        if (ev) begin
            if (m_num == 0 || en < m_num) m_num = en;
            m_pend[en] = 1'b1;
        end
    endtask

    task automatic check(input string req, input logic [2:0] act_n, input logic act_i,
                         input logic [2:0] exp_n, input logic exp_i);
        checks++;
        if (act_n !== exp_n || act_i !== exp_i) begin
            failures++;
            $display("FAIL %s: actual irq=%0b num=%0d expected irq=%0b num=%0d",
                     req, act_i, act_n, exp_i, exp_n);
        end
    endtask

    // drive at negedge, check just after the next rising edge
    task automatic step(input bit ev, input logic [2:0] en, input bit wr,
                        input logic [3:0] ad, input logic [2:0] wd, input string req);
        logic [2:0] old_n;
        logic       old_i;
        @(negedge clk);
        old_n = m_num; old_i = (m_pend != 0);
        ev_valid = ev; ev_num = en; reg_wr = wr; reg_addr = ad; reg_wdata = wd;
        model_step(ev, en, wr, ad, wd);
        #2;
        check("R10 pre-edge", event_num_o, irq_o, old_n, old_i);
        @(posedge clk); #1;
        check(req, event_num_o, irq_o, m_num, m_pend != 0);
        ev_valid = 0; reg_wr = 0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual hung expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        m_pend = 8'b0000_0100; m_num = 3'd2; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 reset", event_num_o, irq_o, 3'd2, 1'b1);

        // R4: three silent clear writes, R5/R6: fourth retires timer event
        step(0, 0, 1, 4'd1, 0, "R4 clear write 1");
        step(0, 0, 1, 4'd1, 0, "R4 clear write 2");
        step(0, 0, 1, 4'd1, 0, "R4 clear write 3");
        step(0, 0, 1, 4'd1, 0, "R6 retire empties, R5 number kept");
        // R11: retire with nothing pending
        repeat (4) step(0, 0, 1, 4'd1, 0, "R11 empty retire");
        // R2 + R3 stale number stays 2
        step(1, 3'd5, 0, 0, 0, "R2 event raises irq, R3 stale 2 kept");
        // R8 write number, then R3 zero rule
        step(0, 0, 1, 4'd0, 3'd0, "R8 number write");
        step(1, 3'd6, 0, 0, 0, "R3 zero overwritten");
        step(1, 3'd3, 0, 0, 0, "R3 smaller wins");
        step(1, 3'd7, 0, 0, 0, "R3 larger ignored");
        // R9 stray address does not advance count
        repeat (4) step(0, 0, 1, 4'd7, 3'd1, "R9 stray write");
        repeat (3) step(0, 0, 1, 4'd1, 0, "R4 silent");
        step(0, 0, 1, 4'd1, 0, "R5 retire lowest 3");
        // R7 same-cycle retire and event
        repeat (3) step(0, 0, 1, 4'd1, 0, "R4 silent");
        step(1, 3'd1, 1, 4'd1, 0, "R7 retire then request");
        // R8 with event in same cycle
        @(negedge clk);
        step(1, 3'd4, 1, 4'd0, 3'd6, "R8 write then compare");
        step(1, 3'd0, 0, 0, 0, "R3 event zero");
        step(1, 3'd5, 0, 0, 0, "R3 zero always overwritten");

        // constrained random
        for (int k = 0; k < 600; k++) begin
            bit         ev = ($urandom_range(0, 99) < 30);
            bit         wr = ($urandom_range(0, 99) < 55);
            int         sel = $urandom_range(0, 9);
            logic [3:0] ad = (sel < 6) ? 4'd1 : (sel < 8) ? 4'd0 : 4'($urandom_range(2, 15));
            step(ev, 3'($urandom_range(0, 7)), wr, ad, 3'($urandom_range(0, 7)), "R3 random mix");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule